// File: doc/BRIEF.md
# Fast Overrange and Gain-Hint Detector

This block sits directly behind a converter that delivers one signed 14-bit sample per clock. It takes the magnitude of every sample, ignoring the sign, and from that single value derives several indications: a coarse nine-step level code, a full-scale (overflow) flag, three programmable threshold flags, and a pair of gain hints. The hints are "reduce gain now" and "gain may be raised, the signal has stayed quiet long enough". An automatic gain loop outside the chip reads these indications to back off the front-end gain before clipping happens, and to raise it again once the input has calmed.

Four output pins carry a subset of these indications. A small register file, written through a plain write-enable / address / data port, holds an enable bit, a 3-bit mode selector and the threshold and dwell values. The mode decides which indications reach which pin. The path from sample input to pins has a fixed latency of two clocks in every mode: one register stage for the magnitude and one for the pins.

Top module: `fd_detect_top`

## Requirements
- R1: The magnitude of a sample is its absolute value, with -8192 treated as 8191. Samples +x and -x produce identical pin values in every mode.
- R2: A sample presented before clock edge k affects the pins directly after edge k+1, and not after edge k.
- R3: The overflow flag is 1 exactly when the sample equals 8191 or -8192.
- R4: The 4-bit level code counts how many of the magnitude boundaries 516, 1543, 2590, 3659, 4606, 5628, 6658 and 7680 the magnitude is greater than or equal to, giving 0 to 8.
- R5: In mode 0 the pins carry the 4-bit level code.
- R6: The 3-bit level is the level code shifted right by one, and the 2-bit level is the level code shifted right by two. A level code of 8 saturates them to 7 and 3. Mode 1 drives pins[3:1]=3-bit level and pin0=overflow. Mode 2 drives pins[3:2]=2-bit level, pin1=overflow and pin0=fine-lower flag. Mode 3 drives pins[3:2]=2-bit level, pin1=coarse-upper flag and pin0=fine-lower flag.
- R7: Mode 4 drives pin3=overflow, pin2=coarse-upper, pin1=fine-upper and pin0=fine-lower.
- R8: Mode 5 drives pin3=overflow, pin2=fine-upper, pin1=increase-gain and pin0=decrease-gain. Decrease-gain equals the fine-upper flag.
- R9: Increase-gain is 1 for a sample whose magnitude is below the fine-lower threshold and which is at least the D-th consecutive such sample, where D is the dwell value. A sample at or above that threshold restarts the count. A dwell of 0 behaves like 1.
- R10: Each threshold flag is 1 only when the magnitude is strictly greater than its threshold. A magnitude equal to the threshold gives 0.
- R11: The pins are 0000 when the enable bit is 0 or when the mode is 6 or 7.
- R12: Register writes use addresses that determine field placement: address 0 holds enable in bit 0 and mode in bits [3:1], address 1 the coarse-upper threshold, address 2 the fine-upper threshold, address 3 the fine-lower threshold (all bits [12:0]), and address 4 the dwell value (bits [15:0]). A write affects the pins from the second edge after it onward. Synchronous reset clears every register, so the pins read 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 14 | Signed two's-complement sample, one per clock |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| fd_o | output | 4 | Fast-detect pins, registered |

## Verification
The embedded assertions check, on every cycle, several relations between the pins and the configuration. A disabled block or a reserved mode yields silent pins one clock later. In the gain mode the decrease-gain pin tracks the fine-upper pin. Increase-gain and decrease-gain never rise together when the lower threshold does not exceed the upper one. The overflow flag implies a full-scale magnitude. Pin positions in the mixed modes, the exact level boundaries, the two-clock latency, sign symmetry and the dwell counting and restart only show up in the bench's scenarios. There a behavioural model predicts the pins on each clock, and directed stimulus probes each boundary value.

// File: rtl/fd_pkg.sv
package fd_pkg;

  typedef enum logic [2:0] {
    MD_LEVEL4   = 3'd0,
    MD_LVL3_OVF = 3'd1,
    MD_LVL2_OVF = 3'd2,
    MD_LVL2_CUT = 3'd3,
    MD_FLAGS    = 3'd4,
    MD_GAIN     = 3'd5,
    MD_RSVD6    = 3'd6,
    MD_RSVD7    = 3'd7
  } fd_mode_e;

  localparam int NUM_BOUNDS = 8;

  // Boundary fraction of full scale, scaled by 2^16, for each coarse step
  function automatic longint bound_frac(input int idx);
    case (idx)
      0:       return 64'd4135;
      1:       return 64'd12345;
      2:       return 64'd20724;
      3:       return 64'd29274;
      4:       return 64'd36854;
      5:       return 64'd45027;
      6:       return 64'd53269;
      default: return 64'd61444;
    endcase
  endfunction

  // Magnitude boundary for a sample width dw
  function automatic longint level_bound(input int idx, input int dw);
    return (bound_frac(idx) << (dw - 1)) >> 16;
  endfunction

endpackage

// File: rtl/fd_cfg_regs.sv
module fd_cfg_regs #(
  parameter int MW = 13,
  parameter int CW = 16,
  parameter int RW = 16,
  parameter int AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [RW-1:0]     wdata,
  output logic              en_q,
  output fd_pkg::fd_mode_e  mode_q,
  output logic [MW-1:0]     cut_q,
  output logic [MW-1:0]     fut_q,
  output logic [MW-1:0]     flt_q,
  output logic [CW-1:0]     dwell_q
);
  import fd_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      mode_q  <= MD_LEVEL4;
      cut_q   <= '0;
      fut_q   <= '0;
      flt_q   <= '0;
      dwell_q <= '0;
    end else if (we) begin
      case (addr)
        AW'(0): begin
          en_q   <= wdata[0];
          mode_q <= fd_mode_e'(wdata[3:1]);
        end
        AW'(1): cut_q   <= wdata[MW-1:0];
        AW'(2): fut_q   <= wdata[MW-1:0];
        AW'(3): flt_q   <= wdata[MW-1:0];
        AW'(4): dwell_q <= wdata[CW-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fd_magnitude.sv
module fd_magnitude #(
  parameter int DW = 14,
  localparam int MW = DW - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] smp_i,
  output logic [MW-1:0]        mag_q,
  output logic                 ovf_q
);
  localparam logic [DW-1:0] SMP_MIN = {1'b1, {MW{1'b0}}};
  localparam logic [DW-1:0] SMP_MAX = {1'b0, {MW{1'b1}}};

  logic [DW-1:0] neg;
  logic [MW-1:0] mag_d;
  logic          ovf_d;

  always_comb begin
    neg   = ~smp_i + DW'(1);
    ovf_d = (smp_i == SMP_MIN) || (smp_i == SMP_MAX);
    if (!smp_i[DW-1])        mag_d = smp_i[MW-1:0];
    else if (smp_i == SMP_MIN) mag_d = '1;
    else                     mag_d = neg[MW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      mag_q <= mag_d;
      ovf_q <= ovf_d;
    end
  end

  AST_OVF_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (mag_q == {MW{1'b1}}));  // R3

endmodule

// File: rtl/fd_level_quant.sv
module fd_level_quant #(
  parameter int DW = 14,
  localparam int MW = DW - 1
) (
  input  logic [MW-1:0] mag_i,
  output logic [3:0]    lvl4_o,
  output logic [2:0]    lvl3_o,
  output logic [1:0]    lvl2_o
);
  import fd_pkg::*;

  logic [NUM_BOUNDS-1:0] hit;

  for (genvar i = 0; i < NUM_BOUNDS; i++) begin : g_cmp
    localparam logic [MW-1:0] BND = MW'(level_bound(i, DW));
    assign hit[i] = (mag_i >= BND);
  end

  always_comb begin
    lvl4_o = 4'($countones(hit));
    if (lvl4_o[3]) begin
      lvl3_o = 3'b111;
      lvl2_o = 2'b11;
    end else begin
      lvl3_o = lvl4_o[3:1];
      lvl2_o = lvl4_o[3:2];
    end
  end

endmodule

// File: rtl/fd_dwell.sv
module fd_dwell #(
  parameter int MW = 13,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] mag_i,
  input  logic [MW-1:0] flt_i,
  input  logic [CW-1:0] dwell_i,
  output logic          ig_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic          below;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    below = (mag_i < flt_i);
    if (!below)                cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                       cnt_d = cnt_q + CW'(1);
    ig_o = below && (cnt_d >= dwell_i);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  AST_DWELL_RESTART: assert property (@(posedge clk) disable iff (rst)
    (mag_i >= flt_i) |=> (cnt_q == '0));  // R9

endmodule

// File: rtl/fd_detect_top.sv
module fd_detect_top #(
  parameter int DW = 14,
  parameter int CW = 16,
  parameter int RW = 16,
  parameter int AW = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] smp_i,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [RW-1:0]        cfg_wdata,
  output logic [3:0]           fd_o
);
  import fd_pkg::*;

  localparam int MW = DW - 1;

  logic          en_q;
  fd_mode_e      mode_q;
  logic [MW-1:0] cut_q, fut_q, flt_q;
  logic [CW-1:0] dwell_q;
  logic [MW-1:0] mag_q;
  logic          ovf_q;
  logic [3:0]    lvl4;
  logic [2:0]    lvl3;
  logic [1:0]    lvl2;
  logic          c_ut, f_ut, f_lt, ig;
  logic [3:0]    fd_d;

  fd_cfg_regs #(.MW(MW), .CW(CW), .RW(RW), .AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .en_q(en_q), .mode_q(mode_q), .cut_q(cut_q), .fut_q(fut_q),
    .flt_q(flt_q), .dwell_q(dwell_q)
  );

  fd_magnitude #(.DW(DW)) u_mag (
    .clk(clk), .rst(rst), .smp_i(smp_i), .mag_q(mag_q), .ovf_q(ovf_q)
  );

  fd_level_quant #(.DW(DW)) u_lvl (
    .mag_i(mag_q), .lvl4_o(lvl4), .lvl3_o(lvl3), .lvl2_o(lvl2)
  );

  fd_dwell #(.MW(MW), .CW(CW)) u_dwell (
    .clk(clk), .rst(rst), .mag_i(mag_q), .flt_i(flt_q),
    .dwell_i(dwell_q), .ig_o(ig)
  );

  always_comb begin
    c_ut = (mag_q > cut_q);
    f_ut = (mag_q > fut_q);
    f_lt = (mag_q > flt_q);
    fd_d = 4'b0000;
    if (en_q) begin
      case (mode_q)
        MD_LEVEL4:   fd_d = lvl4;
        MD_LVL3_OVF: fd_d = {lvl3, ovf_q};
        MD_LVL2_OVF: fd_d = {lvl2, ovf_q, f_lt};
        MD_LVL2_CUT: fd_d = {lvl2, c_ut, f_lt};
        MD_FLAGS:    fd_d = {ovf_q, c_ut, f_ut, f_lt};
        MD_GAIN:     fd_d = {ovf_q, f_ut, ig, f_ut};
        default:     fd_d = 4'b0000;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) fd_o <= 4'b0000;
    else     fd_o <= fd_d;
  end

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en_q || mode_q == MD_RSVD6 || mode_q == MD_RSVD7) |=> (fd_o == 4'b0000));  // R11

  AST_DG_TRACKS_FUT: assert property (@(posedge clk) disable iff (rst)
    (en_q && mode_q == MD_GAIN) |=> (fd_o[0] == fd_o[2]));  // R8

  AST_GAIN_HINTS_EXCL: assert property (@(posedge clk) disable iff (rst)
    (en_q && mode_q == MD_GAIN && flt_q <= fut_q) |=> !(fd_o[1] && fd_o[0]));  // R9

  AST_LEVEL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (en_q && mode_q == MD_LEVEL4) |=> (fd_o <= 4'd8));  // R4

  AST_OVF_ABOVE_CUT: assert property (@(posedge clk) disable iff (rst)
    (en_q && mode_q == MD_FLAGS && cut_q != {MW{1'b1}}) |=> (!fd_o[3] || fd_o[2]));  // R7

endmodule

// File: tb/tb_fd_detect_top.sv
module tb_fd_detect_top;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic signed [13:0] smp_i = '0;
  logic               cfg_we = 1'b0;
  logic [2:0]         cfg_addr = '0;
  logic [15:0]        cfg_wdata = '0;
  logic [3:0]         fd_o;

  int nchk = 0;
  int nerr = 0;
  bit run = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  fd_detect_top dut (
    .clk(clk), .rst(rst), .smp_i(smp_i), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .fd_o(fd_o)
  );

  // ---------------- behavioural reference ----------------
  int bounds[8] = '{516, 1543, 2590, 3659, 4606, 5628, 6658, 7680};
  int m_en, m_mode, m_cut, m_fut, m_flt, m_dwell;
  int s1_m, s1_o, cnt, exp_mode, exp_en;
  logic [3:0] exp_fd;

  function automatic logic [3:0] predict(input int m, input int o);
    int lvl, l3, l2, cu, fu, fl, below, ig;
    lvl = 0;
    foreach (bounds[i]) if (m >= bounds[i]) lvl++;
    l3 = (lvl == 8) ? 7 : lvl / 2;
    l2 = (lvl == 8) ? 3 : lvl / 4;
    cu = (m > m_cut); fu = (m > m_fut); fl = (m > m_flt);
    below = (m < m_flt);
    cnt = below ? ((cnt < 65535) ? cnt + 1 : cnt) : 0;
    ig = below && (cnt >= m_dwell);
    if (m_en == 0) return 4'd0;
    case (m_mode)
      0: return 4'(lvl);
      1: return 4'(l3 * 2 + o);
      2: return 4'(l2 * 4 + o * 2 + fl);
      3: return 4'(l2 * 4 + cu * 2 + fl);
      4: return 4'(o * 8 + cu * 4 + fu * 2 + fl);
      5: return 4'(o * 8 + fu * 4 + ig * 2 + fu);
      default: return 4'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    int v;
    if (rst) begin
      exp_fd = 0; s1_m = 0; s1_o = 0; cnt = 0;
      m_en = 0; m_mode = 0; m_cut = 0; m_fut = 0; m_flt = 0; m_dwell = 0;
      exp_en = 0; exp_mode = 0;
    end else begin
      exp_en = m_en; exp_mode = m_mode;
      exp_fd = predict(s1_m, s1_o);
      v = int'(smp_i);
      s1_o = (v == 8191 || v == -8192) ? 1 : 0;
      s1_m = (v == -8192) ? 8191 : (v < 0 ? -v : v);
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: begin m_en = int'(cfg_wdata[0]); m_mode = int'(cfg_wdata[3:1]); end
          3'd1: m_cut = int'(cfg_wdata[12:0]);
          3'd2: m_fut = int'(cfg_wdata[12:0]);
          3'd3: m_flt = int'(cfg_wdata[12:0]);
          3'd4: m_dwell = int'(cfg_wdata);
          default: ;
        endcase
      end
    end
  end

  function automatic string mode_tag(input int en, input int md);
    if (en == 0 || md > 5) return "R11";
    case (md)
      0: return "R5";
      4: return "R7";
      5: return "R8/R9";
      default: return "R6";
    endcase
  endfunction

  always @(negedge clk) begin
    if (run && !rst && !done) begin
      nchk++;
      if (fd_o !== exp_fd) begin
        nerr++;
        $display("FAIL %s model compare: actual=%b expected=%b",
                 mode_tag(exp_en, exp_mode), fd_o, exp_fd);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [3:0] exp, input string tag);
    nchk++;
    if (fd_o !== exp) begin
      nerr++;
      $display("FAIL %s directed: actual=%b expected=%b", tag, fd_o, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic hold(input int v, input logic [3:0] exp, input string tag);
    smp_i = 14'(v);
    step(2);
    chk(exp, tag);
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int pre;
    step(3);
    rst = 1'b0;
    run = 1;
    step();
    chk(4'd0, "R12");                      // reset state

    wr(0, 16'h0001);                       // enable, mode 0
    smp_i = 0; step(3);
    smp_i = 14'sd8191;                     // latency probe
    step(); chk(4'd0, "R2");
    step(); chk(4'd8, "R2");

    // level boundaries (R4)
    hold(515, 4'd0, "R4");  hold(516, 4'd1, "R4");
    hold(1542, 4'd1, "R4"); hold(1543, 4'd2, "R4");
    hold(2590, 4'd3, "R4"); hold(3659, 4'd4, "R4");
    hold(4606, 4'd5, "R4"); hold(5628, 4'd6, "R4");
    hold(6658, 4'd7, "R4"); hold(7679, 4'd7, "R4");
    hold(7680, 4'd8, "R4");
    hold(-7680, 4'd8, "R1"); hold(-516, 4'd1, "R1");
    hold(-8192, 4'd8, "R1");

    // mode 1
    wr(0, 16'h0003);
    hold(8191, 4'b1111, "R3");
    hold(8190, 4'b1110, "R3");
    hold(-8192, 4'b1111, "R3");
    hold(4606, 4'b0100, "R6");

    // thresholds, mode 4
    wr(1, 4000); wr(2, 3000); wr(3, 1000);
    wr(0, 16'h0009);
    hold(3000, 4'b0001, "R10");
    hold(1000, 4'b0000, "R10");
    hold(3001, 4'b0011, "R10");
    hold(-4001, 4'b0111, "R1");
    hold(-8192, 4'b1111, "R7");

    // mode 3 and mode 2
    wr(0, 16'h0007);
    hold(4001, 4'b0111, "R6");
    wr(0, 16'h0005);
    hold(8000, 4'b1101, "R6");

    // gain mode with dwell 4
    wr(4, 4);
    wr(0, 16'h000B);
    hold(3001, 4'b0101, "R8");
    smp_i = 14'sd500;
    step(4); chk(4'b0000, "R9");
    step();  chk(4'b0010, "R9");
    smp_i = 14'sd1000;
    step();  chk(4'b0010, "R9");
    step();  chk(4'b0000, "R9");
    smp_i = -14'sd500;
    step(2); chk(4'b0000, "R9");

    // disabled / reserved modes
    wr(0, 16'h000D);
    hold(8191, 4'b0000, "R11");
    wr(0, 16'h000F);
    hold(-8192, 4'b0000, "R11");
    wr(0, 16'h0008);
    hold(8191, 4'b0000, "R11");

    // random traffic across all modes, checked by the model each cycle
    for (int blk = 0; blk < 24; blk++) begin
      wr(1, $urandom_range(8191));
      wr(2, $urandom_range(8191));
      wr(3, $urandom_range(3000));
      wr(4, $urandom_range(6));
      wr(0, (blk % 8) * 2 + ((blk % 11 == 10) ? 0 : 1));
      for (int k = 0; k < 300; k++) begin
        pre = $urandom_range(9);
        if (pre == 0)      smp_i = 14'sd8191;
        else if (pre == 1) smp_i = -14'sd8192;
        else if (pre < 5)  smp_i = 14'($signed(12'($urandom)));
        else               smp_i = 14'($urandom);
        step();
      end
    end

    step(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule